// File: doc/BRIEF.md
# System Control Register Block

This block holds the software-visible control state for a small, fixed set of system exceptions. Each exception has a pending bit. Some exceptions also have an enable bit. The core reports each exception's active state on input lines, and the block reflects that state back to software. Software uses a word-wide synchronous register bus to do the following:

- raise or drop pending requests,
- program the vector table base,
- request a system reset through a keyed write,
- fire a software trigger for an external interrupt number,
- keep the per-handler priority bytes.

Hardware sources, such as the tick timer and the fault logic, raise pending requests through pulse inputs. When the core takes an exception, the rising edge of its active line consumes the pending request. Priority arbitration and the external interrupt array sit elsewhere. This block hands the array a strobe with an interrupt number.

Exception bit indices, used on `pend_set_i`, `active_i` and `pend_o`:

| Index | Exception |
|---|---|
| 0 | NMI |
| 1 | memory fault |
| 2 | bus fault |
| 3 | usage fault |
| 4 | supervisor call |
| 5 | debug |
| 6 | deferred service |
| 7 | timer |

A read presented in one cycle returns `bus_rdata` with `bus_rvalid` high in the next cycle. A write takes effect at the clock edge that samples it.

Top module: `sysctl_regs`

## Requirements
- R1: After synchronous reset, `pend_o`, `vecbase_o`, `rst_req_o` and `trig_valid_o` are zero, and the status register at 0xD24 and the control/state register at 0xD04 read as zero.
- R2: Writing bit 31 as 1 to the control/state register at 0xD04 makes NMI (index 0) pending. Reading 0xD04 shows the NMI pending bit at bit 31.
- R3: In a write to 0xD04, bit 28 sets the deferred-service exception (index 6) pending and bit 27 clears it. When both bits are 1, the set wins. The pending bit reads back at bit 28.
- R4: In a write to 0xD04, bit 26 sets the timer exception (index 7) pending and bit 25 clears it. When both bits are 1, the set wins. A pulse on `pend_set_i[7]` also sets it. The pending bit reads back at bit 26.
- R5: A write to 0xD08 stores the value ANDed with 0xFFFFFF80. The stored value drives `vecbase_o` and reads back at 0xD08.
- R6: A write to 0xD0C whose bits 31:16 equal 0x05FA and whose bit 2 is 1 produces a `rst_req_o` pulse exactly one cycle long in the cycle after the write. Any other key, or a clear bit 2, produces no pulse.
- R7: Reading 0xD24 returns:
  - active inputs at bits 0 (memory), 1 (bus), 3 (usage), 7 (supervisor call), 8 (debug), 10 (deferred) and 11 (timer);
  - pending bits at 12 (usage), 13 (memory), 14 (bus) and 15 (supervisor call);
  - enable bits at 16 (memory), 17 (bus) and 18 (usage).
- R8: A write to 0xD24 changes only the three enable bits, taken from bits 16 to 18 of the data. Pending state is unchanged.
- R9: A write to 0xF00 takes the interrupt number from data bits 8:0. If that number is below `NUM_IRQ`, `trig_valid_o` pulses for one cycle after the write with the number on `trig_num_o`. Otherwise nothing happens.
- R10: Twelve priority bytes occupy byte offsets 0xD18 to 0xD23 and reset to zero. Bus lane n of the word at offset 0xD18+4k is byte 4k+n. Each byte is written only when its byte enable is set.
- R11: Reading offset 0x004 returns `NUM_IRQ`/32 - 1.
- R12: Any other offset, including any offset that is not word-aligned, has the following behaviour:
  - a read returns zero;
  - a write changes no state and produces no pulse.
- R13: A rising edge on `active_i[i]` clears pending bit i, unless a set for that exception arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; used by the priority bytes |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pend_set_i | input | 8 | Pending-set pulses per exception index |
| active_i | input | 8 | Active state per exception index, from the core |
| pend_o | output | 8 | Pending vector per exception index |
| vecbase_o | output | 32 | Vector table base |
| rst_req_o | output | 1 | One-cycle system reset request |
| trig_valid_o | output | 1 | Software trigger strobe |
| trig_num_o | output | 9 | Triggered interrupt number |

## Verification
The bench builds the block with `NUM_IRQ` set to 96 instead of the default 64. With that value, the type register must read 2, which shows the count really comes from the parameter. It also puts the trigger boundary at 95/96, so an accepted number and a rejected number sit next to each other. The maximum field value, 511, is another out-of-range case. All register readbacks go through a scoreboard queue. Exceptions 1 to 4 can only be pended by hardware pulses, so those pulses exercise the status word's pending fields.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int EXC_N = 8;

    // Exception indices on the pending / active vectors
    localparam int EX_NMI   = 0;
    localparam int EX_MEM   = 1;
    localparam int EX_BUS   = 2;
    localparam int EX_USAGE = 3;
    localparam int EX_SUPV  = 4;
    localparam int EX_DEBUG = 5;
    localparam int EX_DEFER = 6;
    localparam int EX_TIMER = 7;

    localparam logic [11:0] OFF_INFO   = 12'h004;
    localparam logic [11:0] OFF_INTCTL = 12'hD04;
    localparam logic [11:0] OFF_VBASE  = 12'hD08;
    localparam logic [11:0] OFF_RSTCTL = 12'hD0C;
    localparam logic [11:0] OFF_HPRIO  = 12'hD18;
    localparam logic [11:0] OFF_HSTAT  = 12'hD24;
    localparam logic [11:0] OFF_SWTRIG = 12'hF00;

    localparam int PRIO_BYTES = 12;
    localparam int PRIO_WORDS = PRIO_BYTES / 4;
    localparam int PW_W       = $clog2(PRIO_WORDS);

    localparam int          TRIG_W      = 9;
    localparam logic [15:0] RESET_KEY   = 16'h05FA;
    localparam int          RESET_BIT   = 2;
    localparam logic [31:0] VBASE_MASK  = 32'hFFFF_FF80;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_INFO,
        SEL_INTCTL,
        SEL_VBASE,
        SEL_RSTCTL,
        SEL_HSTAT,
        SEL_SWTRIG,
        SEL_HPRIO
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e        sel;
        logic [PW_W-1:0] prio_word;
    } dec_t;

    typedef struct packed {
        logic [EXC_N-1:0] set;
        logic [EXC_N-1:0] clr;
    } pend_req_t;

    function automatic logic trig_in_range(input logic [TRIG_W-1:0] num, input int limit);
        return int'(num) < limit;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [11:0] addr,
    output dec_t        dec
);
    always_comb begin
        dec.sel       = SEL_NONE;
        dec.prio_word = '0;
        unique case (addr)
            OFF_INFO:   dec.sel = SEL_INFO;
            OFF_INTCTL: dec.sel = SEL_INTCTL;
            OFF_VBASE:  dec.sel = SEL_VBASE;
            OFF_RSTCTL: dec.sel = SEL_RSTCTL;
            OFF_HSTAT:  dec.sel = SEL_HSTAT;
            OFF_SWTRIG: dec.sel = SEL_SWTRIG;
            default:    dec.sel = SEL_NONE;
        endcase
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (addr == OFF_HPRIO + 12'(4 * w)) begin
                dec.sel       = SEL_HPRIO;
                dec.prio_word = PW_W'(w);
            end
        end
    end
endmodule

// File: rtl/sysctl_pend.sv
module sysctl_pend
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pend_req_t        req,
    input  logic [EXC_N-1:0] act_v,
    output logic [EXC_N-1:0] pend
);
    logic [EXC_N-1:0] act_q;
    logic [EXC_N-1:0] clr_eff;
    logic             past_ok;

    // Taking an exception (rising active) consumes its request
    assign clr_eff = req.clr | (act_v & ~act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            act_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            pend    <= req.set | (pend & ~clr_eff);
            act_q   <= act_v;
            past_ok <= 1'b1;
        end
    end

    // R3 / R4: a set in the same cycle as any clear leaves the bit pending
    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (($past(req.set) & ~pend) == '0));

    // R13: a rising active edge with no set leaves the bit clear
    p_consume_r13: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (($past(act_v & ~act_q & ~req.set) & pend) == '0));
endmodule

// File: rtl/sysctl_prio.sv
module sysctl_prio
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PW_W-1:0] word,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    output logic [31:0]     rd_word
);
    logic [7:0] bytes_q [PRIO_BYTES];

    for (genvar b = 0; b < PRIO_BYTES; b++) begin : g_byte
        localparam int WI = b / 4;
        localparam int LN = b % 4;
        logic hit;
        assign hit = wr_en && (word == PW_W'(WI)) && be[LN];
        always_ff @(posedge clk) begin
            if (rst)      bytes_q[b] <= '0;
            else if (hit) bytes_q[b] <= wdata[8*LN +: 8];
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (word == PW_W'(w)) begin
                for (int l = 0; l < 4; l++) rd_word[8*l +: 8] = bytes_q[4*w + l];
            end
        end
    end

    // R10: a lane without its byte enable keeps its old value
    p_lane_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == '0 && !be[0]) |=> $stable(bytes_q[0]));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [3:0]          bus_be,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [EXC_N-1:0]    pend_set_i,
    input  logic [EXC_N-1:0]    active_i,
    output logic [EXC_N-1:0]    pend_o,
    output logic [31:0]         vecbase_o,
    output logic                rst_req_o,
    output logic                trig_valid_o,
    output logic [TRIG_W-1:0]   trig_num_o
);
    localparam logic [31:0] INFO_VAL = 32'(NUM_IRQ / 32 - 1);

    dec_t        dec;
    pend_req_t   preq;
    logic        wr, rd;
    logic [31:0] prio_rd;
    logic [2:0]  hen_q;       // enables: [0]=memory [1]=bus [2]=usage
    logic [31:0] rd_mux;
    logic        past_ok;

    assign wr = bus_valid &&  bus_write;
    assign rd = bus_valid && !bus_write;

    sysctl_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    always_comb begin
        preq.set = pend_set_i;
        preq.clr = '0;
        if (wr && dec.sel == SEL_INTCTL) begin
            preq.set[EX_NMI]   = preq.set[EX_NMI]   | bus_wdata[31];
            preq.set[EX_DEFER] = preq.set[EX_DEFER] | bus_wdata[28];
            preq.set[EX_TIMER] = preq.set[EX_TIMER] | bus_wdata[26];
            preq.clr[EX_DEFER] = bus_wdata[27] && !bus_wdata[28];
            preq.clr[EX_TIMER] = bus_wdata[25] && !bus_wdata[26];
        end
    end

    sysctl_pend u_pend (
        .clk   (clk),
        .rst   (rst),
        .req   (preq),
        .act_v (active_i),
        .pend  (pend_o)
    );

    sysctl_prio u_prio (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr && dec.sel == SEL_HPRIO),
        .word    (dec.prio_word),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .rd_word (prio_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vecbase_o    <= '0;
            hen_q        <= '0;
            rst_req_o    <= 1'b0;
            trig_valid_o <= 1'b0;
            trig_num_o   <= '0;
            past_ok      <= 1'b0;
        end else begin
            past_ok      <= 1'b1;
            rst_req_o    <= 1'b0;
            trig_valid_o <= 1'b0;
            if (wr) begin
                unique case (dec.sel)
                    SEL_VBASE:  vecbase_o <= bus_wdata & VBASE_MASK;
                    SEL_HSTAT:  hen_q     <= bus_wdata[18:16];
                    SEL_RSTCTL: rst_req_o <= (bus_wdata[31:16] == RESET_KEY) && bus_wdata[RESET_BIT];
                    SEL_SWTRIG: begin
                        if (trig_in_range(bus_wdata[TRIG_W-1:0], NUM_IRQ)) begin
                            trig_valid_o <= 1'b1;
                            trig_num_o   <= bus_wdata[TRIG_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.sel)
            SEL_INFO:   rd_mux = INFO_VAL;
            SEL_INTCTL: begin
                rd_mux[31] = pend_o[EX_NMI];
                rd_mux[28] = pend_o[EX_DEFER];
                rd_mux[26] = pend_o[EX_TIMER];
            end
            SEL_VBASE:  rd_mux = vecbase_o;
            SEL_HSTAT:  begin
                rd_mux[0]     = active_i[EX_MEM];
                rd_mux[1]     = active_i[EX_BUS];
                rd_mux[3]     = active_i[EX_USAGE];
                rd_mux[7]     = active_i[EX_SUPV];
                rd_mux[8]     = active_i[EX_DEBUG];
                rd_mux[10]    = active_i[EX_DEFER];
                rd_mux[11]    = active_i[EX_TIMER];
                rd_mux[12]    = pend_o[EX_USAGE];
                rd_mux[13]    = pend_o[EX_MEM];
                rd_mux[14]    = pend_o[EX_BUS];
                rd_mux[15]    = pend_o[EX_SUPV];
                rd_mux[18:16] = hen_q;
            end
            SEL_HPRIO:  rd_mux = prio_rd;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd;
            bus_rdata  <= rd ? rd_mux : '0;
        end
    end

    // R6: the reset request never lasts more than one cycle
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o);

    // R6: a request only follows a keyed write
    p_rst_key_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && rst_req_o) |-> $past(wr && dec.sel == SEL_RSTCTL && bus_wdata[31:16] == RESET_KEY));

    // R9: the strobe never carries an out-of-range number
    p_trig_range_r9: assert property (@(posedge clk) disable iff (rst)
        trig_valid_o |-> (int'(trig_num_o) < NUM_IRQ));

    // R5: the base register follows a write with its low bits cleared
    p_vbase_store_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr && dec.sel == SEL_VBASE)) |-> (vecbase_o == ($past(bus_wdata) & VBASE_MASK)));

    // R12: writes to unmapped offsets leave the base register alone
    p_unmapped_r12: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.sel == SEL_NONE) |=> $stable(vecbase_o));
endmodule

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 96;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  pend_set_i = '0, active_i = '0;
    logic [7:0]  pend_o;
    logic [31:0] vecbase_o;
    logic        rst_req_o, trig_valid_o;
    logic [8:0]  trig_num_o;

    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regs #(.NUM_IRQ(NIRQ)) u_sysctl_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pend_set_i(pend_set_i), .active_i(active_i), .pend_o(pend_o),
        .vecbase_o(vecbase_o), .rst_req_o(rst_req_o),
        .trig_valid_o(trig_valid_o), .trig_num_o(trig_num_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever read data comes back
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("unexpected read data", bus_rdata, 32'hDEAD_BEEF);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse_set(input logic [7:0] m);
        @(negedge clk); pend_set_i = m;
        @(negedge clk); pend_set_i = '0;
    endtask

    task automatic pulse_act(input logic [7:0] m);
        @(negedge clk); active_i = m;
        @(negedge clk); active_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pend_o", {24'b0, pend_o}, 32'h0);
        check("R1 vecbase_o", vecbase_o, 32'h0);
        check("R1 pulses", {30'b0, rst_req_o, trig_valid_o}, 32'h0);
        bus_rd(12'hD24, 32'h0, "R1 status after reset");
        bus_rd(12'hD04, 32'h0, "R1 control after reset");

        bus_rd(12'h004, 32'd2, "R11 type value");

        // R2
        bus_wr(12'hD04, 32'h8000_0000);
        bus_rd(12'hD04, 32'h8000_0000, "R2 NMI pending");
        check("R2 pend_o", {24'b0, pend_o}, 32'h01);

        // R3
        bus_wr(12'hD04, 32'h1000_0000);
        bus_rd(12'hD04, 32'h9000_0000, "R3 deferred set");
        bus_wr(12'hD04, 32'h0800_0000);
        bus_rd(12'hD04, 32'h8000_0000, "R3 deferred clear");
        bus_wr(12'hD04, 32'h1800_0000);
        bus_rd(12'hD04, 32'h9000_0000, "R3 set beats clear");
        bus_wr(12'hD04, 32'h0800_0000);
        bus_rd(12'hD04, 32'h8000_0000, "R3 deferred clear again");

        // R4
        bus_wr(12'hD04, 32'h0600_0000);
        bus_rd(12'hD04, 32'h8400_0000, "R4 set beats clear");
        bus_wr(12'hD04, 32'h0200_0000);
        bus_rd(12'hD04, 32'h8000_0000, "R4 timer clear");
        pulse_set(8'h80);
        bus_rd(12'hD04, 32'h8400_0000, "R4 timer pulse sets");

        // R13
        pulse_act(8'h01);
        bus_rd(12'hD04, 32'h0400_0000, "R13 NMI consumed");
        pulse_act(8'h80);
        bus_rd(12'hD04, 32'h0000_0000, "R13 timer consumed");
        @(negedge clk); pend_set_i = 8'h40; active_i = 8'h40;
        @(negedge clk); pend_set_i = '0;    active_i = '0;
        bus_rd(12'hD04, 32'h1000_0000, "R13 same-cycle set survives");
        bus_wr(12'hD04, 32'h0800_0000);
        check("R13 pend_o empty", {24'b0, pend_o}, 32'h0);

        // R5
        bus_wr(12'hD08, 32'hFFFF_FFFF);
        check("R5 vecbase_o mask", vecbase_o, 32'hFFFF_FF80);
        bus_rd(12'hD08, 32'hFFFF_FF80, "R5 readback");
        bus_wr(12'hD08, 32'h1234_56FF);
        bus_rd(12'hD08, 32'h1234_5680, "R5 readback 2");

        // R6
        bus_wr(12'hD0C, 32'h05FA_0004);
        check("R6 pulse high", {31'b0, rst_req_o}, 32'h1);
        @(negedge clk);
        check("R6 pulse one cycle", {31'b0, rst_req_o}, 32'h0);
        bus_wr(12'hD0C, 32'h05FB_0004);
        check("R6 wrong key", {31'b0, rst_req_o}, 32'h0);
        bus_wr(12'hD0C, 32'h05FA_0000);
        check("R6 no request bit", {31'b0, rst_req_o}, 32'h0);

        // R7 / R8 / R13
        pulse_set(8'h1E);
        bus_rd(12'hD24, 32'h0000_F000, "R7 pending fields");
        bus_wr(12'hD24, 32'hFFFF_FFFF);
        bus_rd(12'hD24, 32'h0007_F000, "R8 only enables change");
        bus_wr(12'hD24, 32'h0002_0000);
        bus_rd(12'hD24, 32'h0002_F000, "R8 enable clear");
        @(negedge clk); active_i = 8'hFE;
        bus_rd(12'hD24, 32'h0002_0D8B, "R7 active fields, R13 consumed");
        check("R13 pend_o after active", {24'b0, pend_o}, 32'h0);
        @(negedge clk); active_i = '0;

        // R9
        bus_wr(12'hF00, 32'd95);
        check("R9 top in-range valid", {31'b0, trig_valid_o}, 32'h1);
        check("R9 top in-range num", {23'b0, trig_num_o}, 32'd95);
        @(negedge clk);
        check("R9 strobe one cycle", {31'b0, trig_valid_o}, 32'h0);
        bus_wr(12'hF00, 32'd96);
        check("R9 count ignored", {31'b0, trig_valid_o}, 32'h0);
        bus_wr(12'hF00, 32'h0000_01FF);
        check("R9 max field ignored", {31'b0, trig_valid_o}, 32'h0);
        bus_wr(12'hF00, 32'hFFFF_FE05);
        check("R9 field bits valid", {31'b0, trig_valid_o}, 32'h1);
        check("R9 field bits num", {23'b0, trig_num_o}, 32'd5);

        // R10
        bus_wr(12'hD18, 32'hAABB_CCDD, 4'b0101);
        bus_rd(12'hD18, 32'h00BB_00DD, "R10 lanes 0 and 2");
        bus_wr(12'hD20, 32'h7F11_2233, 4'b1000);
        bus_rd(12'hD20, 32'h7F00_0000, "R10 last byte");
        bus_rd(12'hD1C, 32'h0000_0000, "R10 middle word untouched");

        // R12
        bus_rd(12'hD10, 32'h0, "R12 unmapped read");
        bus_rd(12'hD09, 32'h0, "R12 misaligned read");
        bus_wr(12'hD10, 32'hFFFF_FFFF);
        check("R12 no pulses", {30'b0, rst_req_o, trig_valid_o}, 32'h0);
        bus_wr(12'hD0A, 32'hFFFF_FFFF);
        bus_rd(12'hD08, 32'h1234_5680, "R12 base unchanged");
        bus_rd(12'hD24, 32'h0002_0000, "R12 status unchanged");
        bus_rd(12'hD04, 32'h0, "R12 control unchanged");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule